// File: doc/BRIEF.md
# Pixel Stream Register Front End

This block is the processor-facing side of a controller that drives chains of serially addressed RGB pixels. A 32-bit register bus with single-cycle writes and one-cycle registered reads reaches seven registers. They hold a run control with colour order and frame length, the four bit-cell timing fields, the chain size and inter-frame gap, a refill threshold, the interrupt enables, and the interrupt status. Words written to the data address enter a pixel FIFO. A downstream serializer drains the FIFO through a valid/ready pair and reports the end of each frame with a one-cycle pulse.

Software or a DMA engine keeps the FIFO topped up. A request line stays high while the FIFO holds no more words than the programmed threshold. Software starts a frame by setting the run bit together with a nonzero length. The block clears that bit by itself when the serializer reports completion, and it latches a completion status at the same edge. Both status bits clear when 1 is written to them. An interrupt output combines the status bits through per-source enables and one global gate.

Top module: `pxf_front`

## Requirements
- R1: After a synchronous active-low reset, the control, timing, chain, threshold and enable registers read zero. `irq` and `run` are low and `pix_valid` is low.
- R2: Only defined fields are stored and read back. Reads return one cycle after `rd_en`. Address map: control 0x00 with run at bit 0, colour order at bits 8:6 and length at bits 28:16. Timing 0x04 with one-high at 26:21, one-low at 20:16, zero-high at 10:6 and zero-low at 5:0. Chain 0x0C with LED count minus one at 9:0 and gap at 31:16. Data 0x14. Threshold 0x18 at bits 4:0. Enable 0x1C. Status 0x20.
- R3: Each write to 0x14 pushes one word. `pix_data` presents the words in write order while `pix_valid` is high. A read of 0x14 returns zero.
- R4: The FIFO holds 32 words. A data write while it is full is dropped, and the stored words are unaffected.
- R5: `drq` is high exactly when the FIFO occupancy is less than or equal to the threshold.
- R6: Status bit 1 is set on every cycle after `drq` is high. Clearing it works only once `drq` has fallen.
- R7: A control write with bit 0 set and a nonzero length sets `run`. A write with a zero length leaves `run` low.
- R8: A `frame_done` pulse while `run` is high clears `run` and sets status bit 0 at the same edge. A `frame_done` pulse while `run` is low has no effect.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: `irq` equals the global enable (enable bit 5) AND the OR of status bits 1:0 ANDed with enable bits 1:0.
- R11: The colour order, length, the four timing fields, the LED count and the gap appear on the configuration outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| pix_valid | output | 1 | FIFO holds a word |
| pix_data | output | 32 | Head word of the FIFO |
| pix_ready | input | 1 | Serializer takes the head word |
| frame_done | input | 1 | One-cycle pulse at end of frame |
| run | output | 1 | Frame in progress |
| color_order | output | 3 | Colour order code |
| frame_len | output | 13 | Frame length in pixels |
| t_one_hi | output | 6 | High time of a 1 bit, cycles |
| t_one_lo | output | 5 | Low time of a 1 bit, cycles |
| t_zero_hi | output | 5 | High time of a 0 bit, cycles |
| t_zero_lo | output | 6 | Low time of a 0 bit, cycles |
| led_cnt_m1 | output | 10 | LED count minus one |
| rst_gap | output | 16 | Inter-frame gap, cycles |
| drq | output | 1 | Refill request |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `frame_done` is a single-cycle pulse and that no control write happens in the cycle of a completion. The stimulus performs one bus operation at a time, driven between clock edges. It pulses `frame_done` only while the bus is idle. It raises `pix_ready` only when it means to consume a word, and it also tries pops on an empty FIFO, which must be ignored.

// File: rtl/pxf_pkg.sv
// Shared constants for the pixel stream front end: register offsets and
// field positions. Assumes a byte-addressed 32-bit register bus.
package pxf_pkg;
    localparam int ADDR_W = 8;
    localparam int REG_W  = 32;
    localparam int LVL_W  = 5;
    localparam int LEN_W  = 13;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TIME  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CHAIN = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_THR   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IE    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_STS   = 8'h20;

    typedef struct packed {
        logic [5:0] one_hi;
        logic [4:0] one_lo;
        logic [4:0] zero_hi;
        logic [5:0] zero_lo;
    } bit_time_t;
endpackage

// File: rtl/pxf_fifo.sv
// Pixel word FIFO. Pushes while full are dropped; pops while empty are
// ignored. Head word is presented without a read cycle.
// Assumes a single clock and synchronous active-low reset.
module pxf_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, push_ok, pop_ok;

    assign full      = (count == CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign push_ok   = push && !full;
    assign pop_ok    = pop && out_valid;
    assign out_data  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: a push into a full FIFO with no pop leaves occupancy unchanged.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // R3: an unconsumed head word stays valid and unchanged.
    p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pop) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pxf_regs.sv
// Register file, run control, status and interrupt logic for the pixel
// stream front end. Reads are registered; status bits are write-one-to-
// clear with set taking precedence. Assumes one bus operation per cycle.
module pxf_regs
    import pxf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              frame_done,
    output logic              run,
    output logic [2:0]        color_order,
    output logic [LEN_W-1:0]  frame_len,
    output bit_time_t         bit_time,
    output logic [9:0]        led_cnt_m1,
    output logic [15:0]       rst_gap,
    output logic              drq,
    output logic              irq
);
    logic [LVL_W-1:0] level;
    logic [1:0]       ie, sts;
    logic             gie;
    logic             ctrl_wr, sts_wr, done_set;

    assign ctrl_wr  = wr_en && (addr == OFS_CTRL);
    assign sts_wr   = wr_en && (addr == OFS_STS);
    assign done_set = frame_done && run;
    assign drq      = (32'(fifo_count) <= 32'(level));
    assign irq      = gie && |(sts & ie);

    // Control register and self-clearing run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run         <= 1'b0;
            color_order <= '0;
            frame_len   <= '0;
        end else if (ctrl_wr) begin
            run         <= wdata[0] && (wdata[28:16] != '0);
            color_order <= wdata[8:6];
            frame_len   <= wdata[28:16];
        end else if (done_set) begin
            run <= 1'b0;
        end
    end

    // Timing, chain, threshold and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_time   <= '0;
            led_cnt_m1 <= '0;
            rst_gap    <= '0;
            level      <= '0;
            ie         <= '0;
            gie        <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFS_TIME: bit_time <= '{one_hi: wdata[26:21], one_lo: wdata[20:16],
                                        zero_hi: wdata[10:6], zero_lo: wdata[5:0]};
                OFS_CHAIN: begin
                    led_cnt_m1 <= wdata[9:0];
                    rst_gap    <= wdata[31:16];
                end
                OFS_THR:  level <= wdata[LVL_W-1:0];
                OFS_IE: begin
                    ie  <= wdata[1:0];
                    gie <= wdata[5];
                end
                default: ;
            endcase
        end
    end

    // Status: set by events, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts[0] <= done_set | (sts[0] & ~(sts_wr & wdata[0]));
            sts[1] <= drq      | (sts[1] & ~(sts_wr & wdata[1]));
        end
    end

    // Registered read mux; data and unmapped addresses read zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                OFS_CTRL:  rdata <= {3'b0, frame_len, 7'b0, color_order, 5'b0, run};
                OFS_TIME:  rdata <= {5'b0, bit_time.one_hi, bit_time.one_lo, 5'b0,
                                     bit_time.zero_hi, bit_time.zero_lo};
                OFS_CHAIN: rdata <= {rst_gap, 6'b0, led_cnt_m1};
                OFS_THR:   rdata <= {{(REG_W-LVL_W){1'b0}}, level};
                OFS_IE:    rdata <= {26'b0, gie, 3'b0, ie};
                OFS_STS:   rdata <= {30'b0, sts};
                default:   rdata <= '0;
            endcase
        end
    end

    // R6: a request always leaves the request status set.
    p_req_sts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drq |=> sts[1]);

    // R7: a start write with nonzero length raises run.
    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[0] && (wdata[28:16] != '0)) |=> run);

    // R8: completion clears run and latches finish status.
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && run && !ctrl_wr) |=> (!run && sts[0]));
endmodule

// File: rtl/pxf_front.sv
// Top of the pixel stream front end: decodes data-register writes into
// FIFO pushes and joins the FIFO to the register and interrupt logic.
// Assumes the serializer consumes the head word when pix_ready is high.
module pxf_front
    import pxf_pkg::*;
#(
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              pix_valid,
    output logic [REG_W-1:0]  pix_data,
    input  logic              pix_ready,
    input  logic              frame_done,
    output logic              run,
    output logic [2:0]        color_order,
    output logic [LEN_W-1:0]  frame_len,
    output logic [5:0]        t_one_hi,
    output logic [4:0]        t_one_lo,
    output logic [4:0]        t_zero_hi,
    output logic [5:0]        t_zero_lo,
    output logic [9:0]        led_cnt_m1,
    output logic [15:0]       rst_gap,
    output logic              drq,
    output logic              irq
);
    logic [CNT_W-1:0] occ;
    logic             data_push;
    bit_time_t        bt;

    assign data_push = wr_en && (addr == OFS_DATA);
    assign t_one_hi  = bt.one_hi;
    assign t_one_lo  = bt.one_lo;
    assign t_zero_hi = bt.zero_hi;
    assign t_zero_lo = bt.zero_lo;

    pxf_fifo #(.DEPTH(DEPTH), .DATA_W(REG_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(data_push), .push_data(wdata),
        .pop(pix_ready), .out_valid(pix_valid), .out_data(pix_data), .count(occ)
    );

    pxf_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fifo_count(occ), .frame_done(frame_done),
        .run(run), .color_order(color_order), .frame_len(frame_len),
        .bit_time(bt), .led_cnt_m1(led_cnt_m1), .rst_gap(rst_gap),
        .drq(drq), .irq(irq)
    );
endmodule

// File: tb/test_pxf_front.sv
module test_pxf_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, pix_ready = 1'b0, frame_done = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, pix_data;
    logic        pix_valid, run, drq, irq;
    logic [2:0]  color_order;
    logic [12:0] frame_len;
    logic [5:0]  t_one_hi, t_zero_lo;
    logic [4:0]  t_one_lo, t_zero_hi;
    logic [9:0]  led_cnt_m1;
    logic [15:0] rst_gap;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pxf_front i_pxf_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .frame_done(frame_done), .run(run),
        .color_order(color_order), .frame_len(frame_len), .t_one_hi(t_one_hi),
        .t_one_lo(t_one_lo), .t_zero_hi(t_zero_hi), .t_zero_lo(t_zero_lo),
        .led_cnt_m1(led_cnt_m1), .rst_gap(rst_gap), .drq(drq), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FIFO_FRONT FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic pop_expect(input string tag, input logic [31:0] exp);
        check(tag, {31'b0, pix_valid}, 32'd1);
        check(tag, pix_data, exp);
        pix_ready = 1'b1;
        @(posedge clk);
        @(negedge clk); pix_ready = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); frame_done = 1'b1;
        @(posedge clk);
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        bus_rd(8'h04, v); check("R1 timing", v, 32'h0);
        bus_rd(8'h1C, v); check("R1 enable", v, 32'h0);
        check("R1 outs", {29'b0, irq, run, pix_valid}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bus_wr(8'h00, 32'hFFFF_FFFE);
        bus_rd(8'h00, v); check("R2 ctrl mask", v, 32'h1FFF_01C0);
        check("R7 no run", {31'b0, run}, 32'h0);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_rd(8'h04, v); check("R2 timing mask", v, 32'h07FF_07FF);
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        bus_rd(8'h0C, v); check("R2 chain mask", v, 32'hFFFF_03FF);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_rd(8'h18, v); check("R2 thr mask", v, 32'h0000_001F);
        bus_wr(8'h1C, 32'hFFFF_FFDC);
        bus_rd(8'h1C, v); check("R2 enable mask", v, 32'h0);
        bus_wr(8'h04, {5'b0, 6'h2A, 5'h13, 5'b0, 5'h0B, 6'h25});
        check("R11 timing outs", {10'b0, t_one_hi, t_one_lo, t_zero_hi, t_zero_lo},
              {10'b0, 6'h2A, 5'h13, 5'h0B, 6'h25});
        bus_wr(8'h0C, {16'hBEEF, 6'b0, 10'h2C5});
        check("R11 chain outs", {rst_gap, 6'b0, led_cnt_m1}, {16'hBEEF, 6'b0, 10'h2C5});
        bus_wr(8'h00, {3'b0, 13'd77, 7'b0, 3'd5, 6'b0});
        check("R11 ctrl outs", {16'b0, frame_len, color_order}, {16'b0, 13'd77, 3'd5});
        bus_wr(8'h18, 32'h0);
        bus_wr(8'h00, 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) bus_wr(8'h14, 32'hA500_0000 + 32'(i * 3));
        bus_rd(8'h14, v); check("R3 data read zero", v, 32'h0);
        for (int i = 0; i < 5; i++) pop_expect("R3 order", 32'hA500_0000 + 32'(i * 3));
        check("R3 empty", {31'b0, pix_valid}, 32'h0);
        pix_ready = 1'b1; @(posedge clk); @(negedge clk); pix_ready = 1'b0;
        check("R3 empty pop ignored", {31'b0, pix_valid}, 32'h0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 33; i++) bus_wr(8'h14, 32'h100 + 32'(i));
        for (int i = 0; i < 32; i++) pop_expect("R4 kept", 32'h100 + 32'(i));
        check("R4 extra dropped", {31'b0, pix_valid}, 32'h0);
    endtask

    task automatic t_drq();
        bus_wr(8'h18, 32'd3);
        check("R5 empty", {31'b0, drq}, 32'd1);
        for (int i = 0; i < 3; i++) bus_wr(8'h14, 32'(i));
        check("R5 at level", {31'b0, drq}, 32'd1);
        bus_wr(8'h14, 32'd3);
        check("R5 above level", {31'b0, drq}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            pop_expect("R5 drain", 32'(i));
            check("R5 below", {31'b0, drq}, 32'd1);
        end
        bus_wr(8'h18, 32'd0);
    endtask

    task automatic t_sts_req();
        logic [31:0] v;
        bus_wr(8'h14, 32'h77);
        check("R6 drq low", {31'b0, drq}, 32'd0);
        bus_rd(8'h20, v); check("R6 sticky", v & 32'h2, 32'h2);
        bus_wr(8'h20, 32'h1);
        bus_rd(8'h20, v); check("R9 write other bit", v & 32'h2, 32'h2);
        bus_wr(8'h20, 32'h2);
        bus_rd(8'h20, v); check("R9 req cleared", v & 32'h2, 32'h0);
        pop_expect("R6 pop", 32'h77);
        bus_rd(8'h20, v); check("R6 reset by drq", v & 32'h2, 32'h2);
        bus_wr(8'h20, 32'h2);
        bus_rd(8'h20, v); check("R6 clear while drq", v & 32'h2, 32'h2);
    endtask

    task automatic t_frame();
        logic [31:0] v;
        bus_wr(8'h00, 32'h0000_0001);
        check("R7 zero length", {31'b0, run}, 32'd0);
        bus_wr(8'h00, {3'b0, 13'd4, 7'b0, 3'd2, 5'b0, 1'b1});
        check("R7 start", {31'b0, run}, 32'd1);
        bus_rd(8'h20, v); check("R8 no finish yet", v & 32'h1, 32'h0);
        pulse_done();
        check("R8 run cleared", {31'b0, run}, 32'd0);
        bus_rd(8'h20, v); check("R8 finish set", v & 32'h1, 32'h1);
        bus_rd(8'h00, v); check("R8 ctrl bit0", v & 32'h1, 32'h0);
        bus_wr(8'h20, 32'h0);
        bus_rd(8'h20, v); check("R9 zero keeps", v & 32'h1, 32'h1);
        bus_wr(8'h20, 32'h1);
        bus_rd(8'h20, v); check("R9 one clears", v & 32'h1, 32'h0);
        pulse_done();
        bus_rd(8'h20, v); check("R8 idle done ignored", v & 32'h1, 32'h0);
    endtask

    task automatic t_irq();
        bus_wr(8'h00, {3'b0, 13'd1, 16'h0001});
        pulse_done();
        bus_wr(8'h1C, 32'h01);
        check("R10 no global", {31'b0, irq}, 32'd0);
        bus_wr(8'h1C, 32'h21);
        check("R10 finish irq", {31'b0, irq}, 32'd1);
        bus_wr(8'h20, 32'h1);
        check("R10 cleared", {31'b0, irq}, 32'd0);
        bus_wr(8'h1C, 32'h22);
        check("R10 req irq", {31'b0, irq}, 32'd1);
        bus_wr(8'h1C, 32'h02);
        check("R10 gate off", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_order();
        t_full();
        t_drq();
        t_sts_req();
        t_frame();
        t_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FIFO_FRONT FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule